// File: doc/BRIEF.md
# Activity-Triggered Throttle Override Timer

This block sits beside a clock-throttling engine and decides when throttling must step aside. It holds two independent down-counters. One serves interrupt activity and the other serves graphics activity. When throttling is enabled and a qualifying event arrives, the matching counter loads its programmed window length, and the block raises an inhibit signal. That signal makes the throttling engine let the processor run at full speed. Each counter loses one count on every 1 ms tick. When both counters have reached zero, inhibit drops and throttling resumes. Expiry produces no interrupt or management event of any kind.

The interrupt-class counter responds to two events: an interrupt-request pulse, or an I/O access to the speaker/system-control port at address 0x0061. The graphics-class counter responds to any access to the graphics controller. Each window length is set through its own write port and can be read back at all times. Typical settings are a few milliseconds for the interrupt window and 50 to 100 milliseconds for the graphics window.

Top module: `susp_mod_override`

## Requirements
- R1: After reset both window-length registers read 0x00 and `inhibit_o` is low.
- R2: A write strobe stores the data byte into that counter's window-length register. The new value appears on the matching readback output in the cycle after the strobe and leaves the other register unchanged.
- R3: The interrupt-class counter loads when `mod_en_i` is high and either `irq_pulse_i` is high or `io_stb_i` is high with `io_addr_i` equal to 16'h0061. An I/O access to any other address does not load it.
- R4: The graphics-class counter loads when `mod_en_i` is high and `gfx_acc_i` is high. A graphics access never loads the interrupt-class counter.
- R5: After a load with value N, `inhibit_o` is high from the cycle after the event. It stays high through the cycle of the N-th following tick and goes low in the cycle after that tick. A counter changes only on ticks.
- R6: An expired counter stays at zero under further ticks, and inhibit remains low until a new qualifying event arrives.
- R7: A qualifying event while a counter runs reloads the full window length. This also holds when a tick arrives in the same cycle, because the event takes precedence over the tick.
- R8: `inhibit_o` is high whenever either counter is non-zero and `mod_en_i` is high.
- R9: While `mod_en_i` is low, `inhibit_o` is low in that same cycle, both counters clear to zero, and events are ignored.
- R10: A window length of 0x00 disables that counter: its events never raise inhibit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mod_en_i | input | 1 | Global throttling enable |
| tick_i | input | 1 | 1 ms timebase pulse, one cycle wide |
| irq_pulse_i | input | 1 | Interrupt-request event |
| io_stb_i | input | 1 | I/O access strobe |
| io_addr_i | input | 16 | I/O port address qualified by `io_stb_i` |
| gfx_acc_i | input | 1 | Graphics-controller access event |
| irq_len_we_i | input | 1 | Write strobe, interrupt window length |
| irq_len_i | input | 8 | Interrupt window length data |
| gfx_len_we_i | input | 1 | Write strobe, graphics window length |
| gfx_len_i | input | 8 | Graphics window length data |
| irq_len_o | output | 8 | Interrupt window length readback |
| gfx_len_o | output | 8 | Graphics window length readback |
| inhibit_o | output | 1 | Throttling inhibit to the modulation engine |

## Verification
The bench builds the block with its default parameters: 8-bit counters, a 16-bit address and a trigger port of 0x0061. It programs short windows of 3 and 5 ticks. With windows that short, every expiry edge, reload-while-running case and overlap of the two windows fits in a few dozen cycles and can be checked cycle by cycle. The same setup covers tick/event collisions, a mid-window disable and the zero-length disable case. The bench does not cover the full 255-tick range.

// File: rtl/susp_mod_pkg.sv
package susp_mod_pkg;
  localparam int unsigned CNT_W    = 8;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned NUM_TMR  = 2;
  localparam int unsigned TMR_IRQ  = 0;
  localparam int unsigned TMR_GFX  = 1;
  localparam logic [15:0] TRIG_PORT = 16'h0061;
endpackage

// File: rtl/win_len_reg.sv
module win_len_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end

  assert_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> q_o == $past(d_i));
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/activity_qual.sv
module activity_qual #(
  parameter int unsigned    ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] TRIG_PORT = 'h61
) (
  input  logic              irq_pulse_i,
  input  logic              io_stb_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              gfx_acc_i,
  output logic              irq_hit_o,
  output logic              gfx_hit_o
);
  logic port_match;
  assign port_match = io_stb_i && (io_addr_i == TRIG_PORT);
  assign irq_hit_o  = irq_pulse_i || port_match;
  assign gfx_hit_o  = gfx_acc_i;

  always_comb begin
    assert_port_only_R3: assert (!(io_stb_i && !irq_pulse_i && io_addr_i != TRIG_PORT) || !irq_hit_o);
  end
endmodule

// File: rtl/speedup_counter.sv
module speedup_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             evt_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             run_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!en_i)                 cnt_q <= '0;
    else if (evt_i)                 cnt_q <= len_i;  // reload wins over tick
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign run_o = cnt_q != '0;

  assert_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && evt_i) |=> cnt_q == $past(len_i));
  assert_dec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !evt_i && tick_i && run_o) |=> cnt_q == $past(cnt_q) - 1'b1);
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !evt_i && !tick_i) |=> $stable(cnt_q));
  assert_stay_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_o && !evt_i) |=> !run_o);
  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !run_o);
endmodule

// File: rtl/susp_mod_override.sv
module susp_mod_override
  import susp_mod_pkg::*;
#(
  parameter int unsigned CW = CNT_W,
  parameter int unsigned AW = ADDR_W,
  parameter logic [AW-1:0] PORT = TRIG_PORT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mod_en_i,
  input  logic          tick_i,
  input  logic          irq_pulse_i,
  input  logic          io_stb_i,
  input  logic [AW-1:0] io_addr_i,
  input  logic          gfx_acc_i,
  input  logic          irq_len_we_i,
  input  logic [CW-1:0] irq_len_i,
  input  logic          gfx_len_we_i,
  input  logic [CW-1:0] gfx_len_i,
  output logic [CW-1:0] irq_len_o,
  output logic [CW-1:0] gfx_len_o,
  output logic          inhibit_o
);
  logic [NUM_TMR-1:0]         we_v, hit_v, run_v;
  logic [NUM_TMR-1:0][CW-1:0] din_v, len_v;

  assign we_v[TMR_IRQ]  = irq_len_we_i;
  assign we_v[TMR_GFX]  = gfx_len_we_i;
  assign din_v[TMR_IRQ] = irq_len_i;
  assign din_v[TMR_GFX] = gfx_len_i;

  activity_qual #(.ADDR_W(AW), .TRIG_PORT(PORT)) u_qual (
    .irq_pulse_i (irq_pulse_i),
    .io_stb_i    (io_stb_i),
    .io_addr_i   (io_addr_i),
    .gfx_acc_i   (gfx_acc_i),
    .irq_hit_o   (hit_v[TMR_IRQ]),
    .gfx_hit_o   (hit_v[TMR_GFX])
  );

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    win_len_reg #(.W(CW)) u_len (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (we_v[t]),
      .d_i    (din_v[t]),
      .q_o    (len_v[t])
    );
    speedup_counter #(.CNT_W(CW)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (mod_en_i),
      .evt_i  (hit_v[t]),
      .tick_i (tick_i),
      .len_i  (len_v[t]),
      .run_o  (run_v[t])
    );
  end

  assign irq_len_o = len_v[TMR_IRQ];
  assign gfx_len_o = len_v[TMR_GFX];
  assign inhibit_o = mod_en_i && (|run_v);

  assert_evt_inhibit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_en_i && irq_pulse_i && irq_len_o != '0) |=> (!mod_en_i || inhibit_o));
  assert_gfx_inhibit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_en_i && gfx_acc_i && gfx_len_o != '0) |=> (!mod_en_i || inhibit_o));
  assert_zero_len_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inhibit_o && len_v == '0) |=> !inhibit_o);
  assert_disabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mod_en_i) |-> !inhibit_o);
endmodule

// File: tb/susp_mod_override_tb.sv
module susp_mod_override_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_en = 1'b0, tick = 1'b0, irq = 1'b0, io = 1'b0, gfx = 1'b0;
  logic [15:0] addr = '0;
  logic        iwe = 1'b0, gwe = 1'b0;
  logic [7:0]  idat = '0, gdat = '0;
  logic [7:0]  ilen, glen;
  logic        inh;

  int n_vec = 0, n_bad = 0;
  logic [7:0] exp_il = '0, exp_gl = '0;
  logic   q_inh[$];
  logic [7:0] q_il[$], q_gl[$];
  string  q_req[$];

  always #2.5 clk = ~clk;

  susp_mod_override dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mod_en_i(mod_en), .tick_i(tick),
    .irq_pulse_i(irq), .io_stb_i(io), .io_addr_i(addr), .gfx_acc_i(gfx),
    .irq_len_we_i(iwe), .irq_len_i(idat), .gfx_len_we_i(gwe), .gfx_len_i(gdat),
    .irq_len_o(ilen), .gfx_len_o(glen), .inhibit_o(inh)
  );

  // monitor: compare one queued item per cycle, just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_inh.size() > 0) begin
        logic e_inh; logic [7:0] e_il, e_gl; string r;
        e_inh = q_inh.pop_front(); e_il = q_il.pop_front();
        e_gl = q_gl.pop_front(); r = q_req.pop_front();
        n_vec++;
        if (inh !== e_inh || ilen !== e_il || glen !== e_gl) begin
          n_bad++;
          $display("FAIL %s: inh=%b len=%h/%h expected inh=%b len=%h/%h",
                   r, inh, ilen, glen, e_inh, e_il, e_gl);
        end
      end
    end
  end

  task automatic step(input logic m, input logic tk, input logic ir, input logic i_o,
                      input logic [15:0] a, input logic g, input logic e_inh, input string r);
    @(negedge clk);
    mod_en = m; tick = tk; irq = ir; io = i_o; addr = a; gfx = g;
    iwe = 1'b0; gwe = 1'b0;
    q_inh.push_back(e_inh); q_il.push_back(exp_il); q_gl.push_back(exp_gl); q_req.push_back(r);
  endtask

  task automatic wr(input logic wi, input logic [7:0] di, input logic wg, input logic [7:0] dg,
                    input string r);
    @(negedge clk);
    tick = 1'b0; irq = 1'b0; io = 1'b0; gfx = 1'b0;
    iwe = wi; idat = di; gwe = wg; gdat = dg;
    if (wi) exp_il = di;
    if (wg) exp_gl = dg;
    q_inh.push_back(1'b0); q_il.push_back(exp_il); q_gl.push_back(exp_gl); q_req.push_back(r);
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #12 rst_n = 1'b1;
    step(0,0,0,0,0,0, 0, "R1 reset state");
    // R10: zero lengths keep inhibit low
    step(1,0,1,0,0,0, 0, "R10 irq with len 0");
    step(1,0,0,0,0,1, 0, "R10 gfx with len 0");
    step(1,0,0,0,0,0, 0, "R10 idle");
    wr(1,8'd3,0,8'd0, "R2 write irq len");
    wr(0,8'd0,1,8'd5, "R2 write gfx len");
    // R9: events ignored while disabled
    step(0,0,1,0,0,1, 0, "R9 events while disabled");
    step(1,0,0,0,0,0, 0, "R9 no latent load");
    // R5/R6: irq window of 3 ticks
    step(1,0,1,0,0,0, 1, "R5 irq load");
    step(1,0,0,0,0,0, 1, "R5 hold no tick");
    step(1,1,0,0,0,0, 1, "R5 tick1");
    step(1,1,0,0,0,0, 1, "R5 tick2");
    step(1,1,0,0,0,0, 0, "R5 tick3 expire");
    step(1,1,0,0,0,0, 0, "R6 stays expired");
    // R3: port decode
    step(1,0,0,1,16'h0060,0, 0, "R3 port 0060 ignored");
    step(1,0,0,1,16'h1061,0, 0, "R3 port 1061 ignored");
    step(1,0,0,0,16'h0061,0, 0, "R3 addr without strobe");
    step(1,0,0,1,16'h0061,0, 1, "R3 port 0061 loads");
    step(1,1,0,0,0,0, 1, "R3 tick1");
    step(1,1,0,0,0,0, 1, "R3 tick2");
    step(1,1,0,0,0,0, 0, "R3 tick3 expire");
    // R4: graphics window 5
    step(1,0,0,0,0,1, 1, "R4 gfx load");
    for (int i = 1; i <= 4; i++) step(1,1,0,0,0,0, 1, "R4 gfx ticking");
    step(1,1,0,0,0,0, 0, "R4 gfx expire");
    // R7: reload extends window
    step(1,0,1,0,0,0, 1, "R7 load");
    step(1,1,0,0,0,0, 1, "R7 tick to 2");
    step(1,1,0,0,0,0, 1, "R7 tick to 1");
    step(1,0,1,0,0,0, 1, "R7 reload to 3");
    step(1,1,0,0,0,0, 1, "R7 tick to 2");
    step(1,1,0,0,0,0, 1, "R7 tick to 1");
    step(1,1,0,0,0,0, 0, "R7 expire");
    // R7: event with tick in same cycle loads full value
    step(1,1,1,0,0,0, 1, "R7 event+tick");
    step(1,1,0,0,0,0, 1, "R7 t1");
    step(1,1,0,0,0,0, 1, "R7 t2");
    step(1,1,0,0,0,0, 0, "R7 t3 expire");
    // R9: disable mid-window
    step(1,0,1,0,0,0, 1, "R9 load");
    step(0,0,0,0,0,0, 0, "R9 disable drops inhibit");
    step(1,0,0,0,0,0, 0, "R9 counter cleared");
    // R8: overlap, OR of both
    step(1,0,1,0,0,1, 1, "R8 both load");
    step(1,1,0,0,0,0, 1, "R8 t1");
    step(1,1,0,0,0,0, 1, "R8 t2");
    step(1,1,0,0,0,0, 1, "R8 t3 irq done gfx runs");
    step(1,1,0,0,0,0, 1, "R8 t4");
    step(1,1,0,0,0,0, 0, "R8 t5 all expired");
    // R4: gfx does not load irq timer
    wr(0,8'd0,1,8'd0, "R2 gfx len to 0");
    step(1,0,0,0,0,1, 0, "R4 gfx does not touch irq");
    step(1,0,1,0,0,0, 1, "R10 irq still active");
    step(1,0,0,0,0,0, 1, "R8 irq only holds");
    @(negedge clk);
    mod_en = 1'b0; irq = 1'b0;
    @(negedge clk);
    if (q_inh.size() != 0) begin
      n_bad++;
      $display("FAIL queue: actual=%0d expected=0", q_inh.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule